// File: doc/BRIEF.md
# Configuration Stream Sync and Integrity Guard

This block watches the 32-bit word stream that a configuration port hands to the configuration engine. Every word it receives before a fixed alignment pattern is thrown away. Once the pattern is found, the block reads the remaining stream as two-word packets. Each packet is an opcode word followed by one data word.

Three packet kinds matter. The first writes an identity word, which is compared with an identity built into the block. The second carries a frame word. The third carries the CRC value the stream expects. Frame words reach the output only after an identity write has matched. A running CRC is kept over the packet words. When a CRC packet arrives, its value is compared with the running CRC. A mismatch drives the active-low init line Low and stops the block until reset.

The input is a valid/ready word stream. Ready is High at all times except after an abort.

Top module: `cfg_stream_guard`

## Requirements
- R1: After reset, `synced`, `id_err`, `crc_err` and `frame_valid` are Low, and `in_ready` and `init_n` are High.
- R2: Every word before the first accepted word equal to `SYNC_PATTERN` (default 32'hAA995566) is discarded. `synced` goes High in the cycle after that word is accepted and stays High until reset. A word is accepted when `in_valid` and `in_ready` are both High.
- R3: After sync, accepted words alternate between opcode and data. The opcode values are 32'h00000001 (identity write), 32'h00000002 (frame) and 32'h00000003 (CRC check). Any other opcode value makes its packet a no-op.
- R4: The data word of an accepted frame packet appears on `frame_data`, with `frame_valid` High for exactly one cycle, in the cycle after acceptance. This happens only if an earlier identity write matched `DEVICE_ID` and `id_err` is Low.
- R5: An identity write whose data differs from `DEVICE_ID` sets `id_err` in the next cycle. `id_err` stays set until reset. While it is set, no frame word is delivered, even after a later identity write that matches.
- R6: The CRC is CRC-32 with polynomial 0x04C11DB7, an all-zero seed, no reflection and no final XOR. It is fed one word at a time, MSB first. It covers the opcode and data words of every packet except CRC check packets. It is cleared when sync is found and after every CRC check that does not abort.
- R7: When `crc_check_en` is High and a CRC check value differs from the running CRC, `crc_err` goes High and `init_n` goes Low in the next cycle. Both stay that way until reset.
- R8: When `crc_check_en` is Low, no CRC check raises `crc_err`, and the stream continues.
- R9: After a CRC error, `in_ready` is Low. No word is accepted, no frame word is delivered, and no status output changes until reset.
- R10: A word equal to the sync pattern that arrives after sync is handled as an ordinary opcode or data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Stream word is present |
| in_data | input | 32 | Stream word |
| in_ready | output | 1 | Block can take a word (Low only after an abort) |
| crc_check_en | input | 1 | Enables the CRC comparison |
| synced | output | 1 | Sync pattern has been found |
| id_err | output | 1 | Sticky identity mismatch |
| crc_err | output | 1 | Sticky CRC mismatch |
| init_n | output | 1 | Active-low init line, Low on a CRC error |
| frame_valid | output | 1 | One-cycle strobe for a delivered frame word |
| frame_data | output | 32 | Delivered frame word |

## Verification
The bench keeps the default sync pattern and CRC polynomial. It overrides `DEVICE_ID` to 32'h5EC0_1D42, so that a mismatch has to come from the compare itself and not from a reset-like value such as zero. With these values, the bench can drive a matching and a failing identity, correct and corrupted CRC values with the check enabled and disabled, stray sync patterns inside packets, and input gaps while the stream is running.

// File: rtl/cfg_guard_pkg.sv
package cfg_guard_pkg;
    localparam int WORD_W = 32;
    typedef logic [WORD_W-1:0] word_t;

    localparam word_t OPC_IDENT = 32'h0000_0001;
    localparam word_t OPC_FRAME = 32'h0000_0002;
    localparam word_t OPC_CHECK = 32'h0000_0003;

    typedef enum logic [1:0] {ST_HUNT, ST_OPC, ST_DATA, ST_HALT} gstate_e;
    typedef enum logic [1:0] {PK_NOP, PK_IDENT, PK_FRAME, PK_CHECK} pkind_e;

    function automatic pkind_e decode_opc(input word_t w);
        case (w)
            OPC_IDENT: return PK_IDENT;
            OPC_FRAME: return PK_FRAME;
            OPC_CHECK: return PK_CHECK;
            default:   return PK_NOP;
        endcase
    endfunction
endpackage

// File: rtl/cfg_sync_match.sv
module cfg_sync_match
    import cfg_guard_pkg::*;
#(
    parameter word_t PATTERN = 32'hAA99_5566
) (
    input  logic  take,
    input  logic  armed,
    input  word_t word,
    output logic  hit
);
    always_comb begin
        hit = take && armed && (word == PATTERN);
    end
endmodule

// File: rtl/cfg_crc32_acc.sv
module cfg_crc32_acc
    import cfg_guard_pkg::*;
#(
    parameter word_t POLY = 32'h04C1_1DB7
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  clear,
    input  logic  update,
    input  word_t word,
    output word_t crc
);
    word_t crc_d, crc_q;

    always_comb begin
        crc_d = crc_q;
        if (clear) begin
            crc_d = '0;
        end else if (update) begin
            for (int i = WORD_W - 1; i >= 0; i--) begin
                if (crc_d[WORD_W-1] ^ word[i]) begin
                    crc_d = {crc_d[WORD_W-2:0], 1'b0} ^ POLY;
                end else begin
                    crc_d = {crc_d[WORD_W-2:0], 1'b0};
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) crc_q <= '0;
        else        crc_q <= crc_d;
    end

    assign crc = crc_q;
endmodule

// File: rtl/cfg_stream_guard.sv
module cfg_stream_guard
    import cfg_guard_pkg::*;
#(
    parameter word_t SYNC_PATTERN = 32'hAA99_5566,
    parameter word_t DEVICE_ID    = 32'h0123_4567,
    parameter word_t CRC_POLY     = 32'h04C1_1DB7
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic [31:0] in_data,
    output logic        in_ready,
    input  logic        crc_check_en,
    output logic        synced,
    output logic        id_err,
    output logic        crc_err,
    output logic        init_n,
    output logic        frame_valid,
    output logic [31:0] frame_data
);
    typedef struct packed {
        gstate_e st;
        pkind_e  kind;
        logic    synced;
        logic    id_ok;
        logic    id_err;
        logic    crc_err;
        logic    fv;
        word_t   fd;
    } guard_t;

    guard_t s_d, s_q;
    logic   take;
    logic   sync_hit;
    logic   crc_clear;
    logic   crc_upd;
    word_t  crc_now;

    assign in_ready = (s_q.st != ST_HALT);
    assign take     = in_valid && in_ready;

    cfg_sync_match #(.PATTERN(SYNC_PATTERN)) u_sync (
        .take  (take),
        .armed (s_q.st == ST_HUNT),
        .word  (in_data),
        .hit   (sync_hit)
    );

    cfg_crc32_acc #(.POLY(CRC_POLY)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (crc_clear),
        .update (crc_upd),
        .word   (in_data),
        .crc    (crc_now)
    );

    always_comb begin
        s_d       = s_q;
        s_d.fv    = 1'b0;
        crc_clear = 1'b0;
        crc_upd   = 1'b0;
        case (s_q.st)
            ST_HUNT: begin
                if (sync_hit) begin
                    s_d.st     = ST_OPC;
                    s_d.synced = 1'b1;
                    crc_clear  = 1'b1;
                end
            end
            ST_OPC: begin
                if (take) begin
                    s_d.kind = decode_opc(in_data);
                    s_d.st   = ST_DATA;
                    crc_upd  = (decode_opc(in_data) != PK_CHECK);
                end
            end
            ST_DATA: begin
                if (take) begin
                    s_d.st = ST_OPC;
                    case (s_q.kind)
                        PK_IDENT: begin
                            crc_upd = 1'b1;
                            if (in_data == DEVICE_ID) s_d.id_ok  = 1'b1;
                            else                      s_d.id_err = 1'b1;
                        end
                        PK_FRAME: begin
                            crc_upd = 1'b1;
                            if (s_q.id_ok && !s_q.id_err) begin
                                s_d.fv = 1'b1;
                                s_d.fd = in_data;
                            end
                        end
                        PK_CHECK: begin
                            if (crc_check_en && (in_data != crc_now)) begin
                                s_d.crc_err = 1'b1;
                                s_d.st      = ST_HALT;
                            end else begin
                                crc_clear = 1'b1;
                            end
                        end
                        default: crc_upd = 1'b1;
                    endcase
                end
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: ST_HUNT, kind: PK_NOP, synced: 1'b0, id_ok: 1'b0,
                     id_err: 1'b0, crc_err: 1'b0, fv: 1'b0, fd: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign synced      = s_q.synced;
    assign id_err      = s_q.id_err;
    assign crc_err     = s_q.crc_err;
    assign init_n      = !s_q.crc_err;
    assign frame_valid = s_q.fv;
    assign frame_data  = s_q.fd;
endmodule

// File: rtl/cfg_stream_guard_chk.sv
module cfg_stream_guard_chk (
    input logic clk,
    input logic rst_n,
    input logic in_valid,
    input logic in_ready,
    input logic crc_check_en,
    input logic synced,
    input logic id_err,
    input logic crc_err,
    input logic init_n,
    input logic frame_valid
);
    AST_SYNC_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        synced |=> synced); // R2
    AST_FRAME_GATED: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |-> (synced && !id_err)); // R4
    AST_IDERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        id_err |=> id_err); // R5
    AST_CRCERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> (crc_err && !init_n)); // R7
    AST_CRCERR_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(crc_err) |-> $past(crc_check_en)); // R8
    AST_HALT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        crc_err |=> (!in_ready && !frame_valid && $stable(id_err))); // R9
endmodule

bind cfg_stream_guard cfg_stream_guard_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .in_ready     (in_ready),
    .crc_check_en (crc_check_en),
    .synced       (synced),
    .id_err       (id_err),
    .crc_err      (crc_err),
    .init_n       (init_n),
    .frame_valid  (frame_valid)
);

// File: tb/cfg_stream_guard_bench.sv
`timescale 1ns/1ps
module cfg_stream_guard_bench;
    localparam logic [31:0] SYNC = 32'hAA99_5566;
    localparam logic [31:0] DEVID = 32'h5EC0_1D42;
    localparam logic [31:0] POLY = 32'h04C1_1DB7;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [31:0] in_data = '0;
    logic        crc_check_en = 1'b1;
    logic        in_ready, synced, id_err, crc_err, init_n, frame_valid;
    logic [31:0] frame_data;

    always #10 clk = ~clk;

    cfg_stream_guard #(.SYNC_PATTERN(SYNC), .DEVICE_ID(DEVID), .CRC_POLY(POLY)) u_cfg_stream_guard (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .crc_check_en(crc_check_en), .synced(synced),
        .id_err(id_err), .crc_err(crc_err), .init_n(init_n),
        .frame_valid(frame_valid), .frame_data(frame_data)
    );

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    string cur_req  = "R1";
    bit    done     = 1'b0;

    // behavioural reference: phase 0 hunting, 1 expecting opcode, 2 expecting data, 3 halted
    int          m_phase;
    logic [31:0] m_op;
    logic [31:0] m_crc;
    bit          m_synced, m_idok, m_iderr, m_crcerr, m_fv;
    logic [31:0] m_fd;
    logic [31:0] frames_q[$];

    function automatic logic [31:0] crc_feed(logic [31:0] c, logic [31:0] w);
        logic [31:0] r = c;
        for (int b = 31; b >= 0; b--) begin
            logic top = r[31] ^ w[b];
            r = r << 1;
            if (top) r = r ^ POLY;
        end
        return r;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_phase = 0; m_op = '0; m_crc = '0; m_synced = 0; m_idok = 0;
            m_iderr = 0; m_crcerr = 0; m_fv = 0; m_fd = '0;
        end else begin
            m_fv = 0;
            if (in_valid && m_phase != 3) begin
                if (m_phase == 0) begin
                    if (in_data == SYNC) begin m_phase = 1; m_synced = 1; m_crc = '0; end
                end else if (m_phase == 1) begin
                    m_op = in_data;
                    if (in_data != 32'd3) m_crc = crc_feed(m_crc, in_data);
                    m_phase = 2;
                end else begin
                    m_phase = 1;
                    if (m_op == 32'd3) begin
                        if (crc_check_en && in_data != m_crc) begin m_crcerr = 1; m_phase = 3; end
                        else m_crc = '0;
                    end else begin
                        m_crc = crc_feed(m_crc, in_data);
                        if (m_op == 32'd1) begin
                            if (in_data == DEVID) m_idok = 1; else m_iderr = 1;
                        end else if (m_op == 32'd2 && m_idok && !m_iderr) begin
                            m_fv = 1; m_fd = in_data;
                        end
                    end
                end
            end
        end
    end

    task automatic chk(string what, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", cur_req, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk("in_ready",    {31'd0, in_ready},    {31'd0, m_phase != 3});
            chk("synced",      {31'd0, synced},      {31'd0, m_synced});
            chk("id_err",      {31'd0, id_err},      {31'd0, m_iderr});
            chk("crc_err",     {31'd0, crc_err},     {31'd0, m_crcerr});
            chk("init_n",      {31'd0, init_n},      {31'd0, !m_crcerr});
            chk("frame_valid", {31'd0, frame_valid}, {31'd0, m_fv});
            if (m_fv) chk("frame_data", frame_data, m_fd);
        end
    end

    task automatic send(logic [31:0] w);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = w;
    endtask

    task automatic idle(int n);
        @(negedge clk);
        in_valid = 1'b0;
        in_data  = 32'hDEAD_BEEF;
        repeat (n - 1) @(negedge clk);
    endtask

    task automatic send_check(bit good);
        send(32'd3);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = good ? m_crc : (m_crc ^ 32'h0000_0100);
    endtask

    task automatic do_reset;
        @(negedge clk);
        in_valid = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles == 100000 && !done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog (R1..): actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        cur_req = "R1";
        do_reset;
        idle(2);
        chk("reset init_n R1", {31'd0, init_n}, 32'd1);
        chk("reset synced R1", {31'd0, synced}, 32'd0);

        cur_req = "R2";
        send(32'h0000_0001); send(DEVID); send(32'h0000_0002); send(32'h1111_2222);
        idle(3);
        chk("pre-sync R2", {31'd0, synced}, 32'd0);
        send(SYNC);
        idle(2);
        chk("sync seen R2", {31'd0, synced}, 32'd1);

        cur_req = "R4";
        send(32'd2); send(32'hF0F0_0001);          // frame before identity: dropped
        send(32'd1); send(DEVID);
        send(32'd2); send(32'hA5A5_0002);
        idle(1);
        send(32'd2); send(32'h1234_5678);

        cur_req = "R6";
        send_check(1'b1);
        idle(2);
        chk("good crc R6", {31'd0, crc_err}, 32'd0);

        cur_req = "R3";
        send(32'h0000_0077); send(32'h0BAD_0BAD);   // unknown opcode: no-op
        send(32'd2); send(32'hCAFE_0003);

        cur_req = "R10";
        send(SYNC); send(SYNC);                      // stray pattern as a no-op packet
        send(32'd2); send(SYNC);                     // and as frame data
        send_check(1'b1);
        idle(2);
        chk("stray sync R10", {31'd0, crc_err}, 32'd0);

        cur_req = "R5";
        do_reset;
        send(SYNC);
        send(32'd1); send(DEVID ^ 32'h1);
        send(32'd2); send(32'h0000_AAAA);
        send(32'd1); send(DEVID);
        send(32'd2); send(32'h0000_BBBB);
        idle(2);
        chk("id sticky R5", {31'd0, id_err}, 32'd1);

        cur_req = "R8";
        do_reset;
        crc_check_en = 1'b0;
        send(SYNC);
        send(32'd1); send(DEVID);
        send(32'd2); send(32'h7777_0001);
        send_check(1'b0);
        send(32'd2); send(32'h7777_0002);
        idle(2);
        chk("disabled check R8", {31'd0, crc_err}, 32'd0);
        chk("disabled ready R8", {31'd0, in_ready}, 32'd1);

        cur_req = "R7";
        do_reset;
        crc_check_en = 1'b1;
        send(SYNC);
        send(32'd1); send(DEVID);
        send(32'd2); send(32'h3333_0001);
        send_check(1'b0);
        idle(2);
        chk("crc abort R7", {31'd0, init_n}, 32'd0);

        cur_req = "R9";
        send(32'd2); send(32'h3333_0002);
        send(32'd1); send(DEVID ^ 32'hFF);
        idle(3);
        chk("halted ready R9", {31'd0, in_ready}, 32'd0);
        chk("halted id R9", {31'd0, id_err}, 32'd0);

        cur_req = "R1";
        do_reset;
        idle(2);
        chk("re-reset R1", {31'd0, crc_err}, 32'd0);

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule